// File: doc/BRIEF.md
# Pass/Fail Tally with Lockout

This block keeps two small counts of attempt outcomes and locks itself when failures outnumber successes. On any clock cycle the surrounding logic may present an attempt by raising a valid strobe, with a one-bit result that marks it as a pass or a fail. A pass advances the pass count and a fail advances the fail count. Both counts are 3 bits wide by default and stop at their largest value instead of wrapping.

A magnitude comparator watches the two registered counts all the time. When the fail count is strictly greater than the pass count, the block stops accepting attempts at once. On the next clock edge it raises a lock flag, which stays set until a synchronous reset. A one-cycle pass indicator marks each accepted passing attempt. The rule that decides whether an attempt passed is not part of this block.

Top module: `outcome_tally_lock`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both counts to 0 and drives locked and pass_seen to 0.
- R2: While the block is not frozen, att_valid=1 with att_pass=1 at a clock edge raises pass_cnt by one at that edge, unless it is already at its maximum.
- R3: While the block is not frozen, att_valid=1 with att_pass=0 at a clock edge raises fail_cnt by one at that edge, unless it is already at its maximum.
- R4: An edge with att_valid=0 changes neither count, whatever att_pass is. At most one count changes at any edge.
- R5: Each count saturates at 2^CNT_W-1 (7 by default). Further attempts of that kind leave it at that value.
- R6: The edge after the one at which fail_cnt first exceeds pass_cnt sets locked to 1. Attempts presented at that edge or later are not counted.
- R7: Once set, locked stays 1 until reset. While it is 1, neither count changes.
- R8: Equal counts, including both counts saturated at 7, never cause a lock.
- R9: pass_seen is 1 for exactly the cycle after an edge at which a passing attempt was accepted, including one taken while pass_cnt is saturated. It is 0 after any other edge, and so it is 0 for attempts presented while the block is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| att_valid | input | 1 | An attempt is presented this cycle |
| att_pass | input | 1 | Attempt result: 1 pass, 0 fail |
| pass_cnt | output | CNT_W | Saturating count of passing attempts |
| fail_cnt | output | CNT_W | Saturating count of failing attempts |
| locked | output | 1 | Sticky lockout flag |
| pass_seen | output | 1 | One-cycle pulse for an accepted pass |

## Verification
A wrong count shows up on pass_cnt or fail_cnt one edge after the attempt that caused it. It then steers locked one edge later, so a counting fault in either direction appears at the ports within two cycles. A freeze that releases too early shows as a count moving on the edge that should have been ignored. A lock that fails to latch shows as locked dropping, or as counts still moving after it rose. Saturation faults show as a count wrapping to 0, or as a spurious lock when both counts reach 7.

// File: rtl/tally_pkg.sv
package tally_pkg;
   // Decoded action for one clock edge
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_PASS = 2'd1,
      ACT_FAIL = 2'd2
   } tally_act_t;
endpackage

// File: rtl/tally_sat_counter.sv
module tally_sat_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bump,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 1) begin : g_bad_width
      $error("tally_sat_counter: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                       cnt_q <= '0;
      else if (bump && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign value = cnt_q;

   p_stays_at_top_r5: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == TOP) |=> (cnt_q == TOP));
   p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
      (bump && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (!bump) |=> $stable(cnt_q));
endmodule

// File: rtl/tally_mag_cmp.sv
module tally_mag_cmp #(
   parameter int W = 3
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic         lhs_gt
);
   // Ripple from MSB: gt_c[i] / eq_c[i] describe bits above i-1
   logic [W:0] gt_c;
   logic [W:0] eq_c;

   assign gt_c[W] = 1'b0;
   assign eq_c[W] = 1'b1;

   for (genvar i = W - 1; i >= 0; i--) begin : g_bit
      assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & lhs[i] & ~rhs[i]);
      assign eq_c[i] = eq_c[i+1] & ~(lhs[i] ^ rhs[i]);
   end

   assign lhs_gt = gt_c[0];
endmodule

// File: rtl/tally_lock_ctl.sv
module tally_lock_ctl
   import tally_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic fail_gt,
   input  logic att_valid,
   input  logic att_pass,
   output logic bump_pass,
   output logic bump_fail,
   output logic locked,
   output logic pass_seen
);
   logic       lock_q;
   logic       seen_q;
   logic       freeze;
   tally_act_t act;

   assign freeze = lock_q | fail_gt;

   always_comb begin
      if (!att_valid || freeze) act = ACT_NONE;
      else if (att_pass)        act = ACT_PASS;
      else                      act = ACT_FAIL;
   end

   assign bump_pass = (act == ACT_PASS);
   assign bump_fail = (act == ACT_FAIL);

   always_ff @(posedge clk) begin
      if (rst) begin
         lock_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         lock_q <= lock_q | fail_gt;
         seen_q <= (act == ACT_PASS);
      end
   end

   assign locked    = lock_q;
   assign pass_seen = seen_q;

   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      lock_q |=> lock_q);
   p_one_bump_r4: assert property (@(posedge clk) disable iff (rst)
      !(bump_pass && bump_fail));
   p_seen_needs_pass_r9: assert property (@(posedge clk) disable iff (rst)
      seen_q |-> $past(att_valid && att_pass && !lock_q));
endmodule

// File: rtl/outcome_tally_lock.sv
module outcome_tally_lock #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             att_valid,
   input  logic             att_pass,
   output logic [CNT_W-1:0] pass_cnt,
   output logic [CNT_W-1:0] fail_cnt,
   output logic             locked,
   output logic             pass_seen
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("outcome_tally_lock: CNT_W must be within 1..16");
   end

   logic bump_pass;
   logic bump_fail;
   logic fail_gt;

   tally_sat_counter #(.W(CNT_W)) u_pass_ctr (
      .clk(clk), .rst(rst), .bump(bump_pass), .value(pass_cnt));

   tally_sat_counter #(.W(CNT_W)) u_fail_ctr (
      .clk(clk), .rst(rst), .bump(bump_fail), .value(fail_cnt));

   tally_mag_cmp #(.W(CNT_W)) u_cmp (
      .lhs(fail_cnt), .rhs(pass_cnt), .lhs_gt(fail_gt));

   tally_lock_ctl u_ctl (
      .clk(clk), .rst(rst), .fail_gt(fail_gt),
      .att_valid(att_valid), .att_pass(att_pass),
      .bump_pass(bump_pass), .bump_fail(bump_fail),
      .locked(locked), .pass_seen(pass_seen));

   p_cmp_matches_r6: assert property (@(posedge clk) disable iff (rst)
      fail_gt == (fail_cnt > pass_cnt));
   p_lock_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(fail_cnt > pass_cnt));
   p_frozen_counts_r7: assert property (@(posedge clk) disable iff (rst)
      locked |=> ($stable(pass_cnt) && $stable(fail_cnt)));
   p_idle_no_change_r4: assert property (@(posedge clk) disable iff (rst)
      !att_valid |=> ($stable(pass_cnt) && $stable(fail_cnt)));
endmodule

// File: tb/tb_outcome_tally_lock.sv
module tb_outcome_tally_lock;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       att_valid = 1'b0;
   logic       att_pass = 1'b0;
   logic [2:0] pass_cnt;
   logic [2:0] fail_cnt;
   logic       locked;
   logic       pass_seen;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   outcome_tally_lock #(.CNT_W(3)) dut (
      .clk(clk), .rst(rst), .att_valid(att_valid), .att_pass(att_pass),
      .pass_cnt(pass_cnt), .fail_cnt(fail_cnt),
      .locked(locked), .pass_seen(pass_seen));

   task automatic check(input string req, input int ep, input int ef,
                        input int el, input int es);
      n_checks++;
      if (pass_cnt != ep || fail_cnt != ef || locked != el || pass_seen != es) begin
         n_fail++;
         $display("FAIL %s: got pass=%0d fail=%0d lock=%0d seen=%0d, expected pass=%0d fail=%0d lock=%0d seen=%0d",
                  req, pass_cnt, fail_cnt, locked, pass_seen, ep, ef, el, es);
      end
   endtask

   // drive for one edge, return at the following falling edge
   task automatic step(input logic v, input logic p);
      @(negedge clk);
      att_valid = v;
      att_pass  = p;
      @(negedge clk);
      att_valid = 1'b0;
      att_pass  = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      att_valid = 1'b1;
      att_pass  = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      att_valid = 1'b0;
      att_pass  = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 reset state", 0, 0, 0, 0);
   endtask

   task automatic t_count_and_idle();
      do_reset();
      step(1, 1);
      check("R2 first pass", 1, 0, 0, 1);
      step(0, 1);
      check("R4 idle with pass high", 1, 0, 0, 0);
      step(1, 0);
      check("R3 first fail", 1, 1, 0, 0);
      check("R8 equal counts no lock", 1, 1, 0, 0);
      step(1, 1);
      check("R2 second pass", 2, 1, 0, 1);
      step(0, 0);
      check("R9 pulse one cycle", 2, 1, 0, 0);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 9; i++) step(1, 1);
      check("R5 pass saturates, R9 pulse at top", 7, 0, 0, 1);
      for (int i = 0; i < 9; i++) step(1, 0);
      check("R5 fail saturates", 7, 7, 0, 0);
      step(0, 0);
      check("R8 both at top no lock", 7, 7, 0, 0);
   endtask

   task automatic t_lock();
      do_reset();
      step(1, 1);
      step(1, 1);
      step(1, 0);
      step(1, 0);
      step(1, 0);
      check("R6 majority before lock", 2, 3, 0, 0);
      step(1, 1);
      check("R6 lock next edge, attempt dropped", 2, 3, 1, 0);
      step(1, 0);
      check("R7 frozen fail", 2, 3, 1, 0);
      for (int i = 0; i < 4; i++) step(1, 1);
      check("R7 frozen pass, R9 no pulse", 2, 3, 1, 0);
      do_reset();
      check("R1 reset clears lock", 0, 0, 0, 0);
   endtask

   task automatic t_first_fail();
      do_reset();
      step(1, 0);
      check("R3 fail from zero", 0, 1, 0, 0);
      step(1, 1);
      check("R6 lock after first fail", 0, 1, 1, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_count_and_idle();
      t_saturate();
      t_lock();
      t_first_fail();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule